// File: doc/BRIEF.md
# Serial Input Port with One-Shot Word Width

This block receives a single serial data line, one bit for each pulse of a bit strobe. The strobe is a single-cycle enable, already synchronous to the system clock, that marks each bit-clock edge. Arriving bits are collected into a 32-bit shift buffer. A host reads them out as parallel words through a small command/response handshake.

The host controls how many bits make up a word in three ways. A permanent transfer width stays in force until it is changed. A one-shot count can be armed ahead of time and then applies to the next plain read only, which gives a split transaction: arm first, collect later. A width-carrying read sets the size of a single word and requests it in one command.

A read blocks the host until enough bits have arrived. Bits that arrive while no read is waiting are kept, up to the buffer size. Words shorter than 32 bits come back left-aligned, so that no bit reversal is needed.

Top module: `serin_port`

## Requirements
- R1: After reset, cmd_ready is 1, rsp_valid is 0, overrun is 0, and the transfer width is 32 bits.
- R2: Command op 2 (read) at the permanent width of 32 returns the word with the first bit to arrive at rsp_data[0] and the last at rsp_data[31].
- R3: Op 0 (set width) accepts cmd_arg values 1, 4, 8 or 32 and answers with rsp_err = 0. Any other value answers with rsp_err = 1 and leaves the width unchanged. The answer appears on the clock edge that accepts the command.
- R4: A word of n < 32 bits is left-aligned. The first of its bits is at rsp_data[32-n], its newest bit is at rsp_data[31], and the bits below 32-n are zero.
- R5: Op 1 (arm one-shot) sets the size of the next op-2 read only. The read after that uses the permanent width again.
- R6: Op 1 is accepted only for 1 <= cmd_arg < the current transfer width. Any other value answers with rsp_err = 1 and arms nothing.
- R7: Op 3 (sized read) accepts widths 1 to 8, 16, 24 or 32 and returns a word of that many bits. It also cancels any armed one-shot. Any other width answers with rsp_err = 1 at once and consumes no bits.
- R8: While a read waits for bits, cmd_ready is 0 and no response is given. rsp_valid rises on the clock edge after the edge that records the last bit the read needs.
- R9: Up to 32 bits are kept while no read is pending. A further strobe is discarded and sets overrun, which stays 1 until reset. The kept bits are returned intact.
- R10: Bits beyond the size of a read stay in the buffer and start the next word, in arrival order.
- R11: A successful op 0 cancels an armed one-shot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle pulse: sample bit_in as the next serial bit |
| bit_in | input | 1 | Serial data line |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Command accepted on this edge when cmd_valid is also 1 |
| cmd_op | input | 2 | 0 set width, 1 arm one-shot, 2 read, 3 sized read |
| cmd_arg | input | 6 | Width or count argument for ops 0, 1 and 3 |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Command rejected (valid with rsp_valid) |
| rsp_data | output | 32 | Returned word (valid with rsp_valid on reads) |
| overrun | output | 1 | Sticky flag: a strobe arrived with the buffer full |

## Verification
A wrong bit count shows up at the ports within one read. The word comes back with its bits displaced, or the response arrives a cycle early or late relative to the last strobe. A stale one-shot or width setting appears on the very next read as a word of the wrong size. Because the rejected commands are followed by reads whose size exposes the setting that stayed in force, a setting corrupted by a bad command shows up within one read. A buffer that loses or duplicates bits shows up when surplus bits carry into the next word, or when a full buffer is read back after an overrun.

// File: rtl/serin_pkg.sv
package serin_pkg;
  typedef enum logic [1:0] {
    OP_SETW  = 2'd0,
    OP_ARM   = 2'd1,
    OP_READ  = 2'd2,
    OP_READW = 2'd3
  } op_e;

  // Legal permanent transfer widths
  function automatic logic width_ok(input int unsigned v, input int unsigned full);
    return (v == 1) || (v == 4) || (v == 8) || (v == full);
  endfunction

  // Legal widths for the single-command sized read
  function automatic logic readw_ok(input int unsigned v, input int unsigned full);
    return ((v >= 1) && (v <= 8)) || (v == 16) || (v == 24) || (v == full);
  endfunction
endpackage

// File: rtl/serin_width_ctl.sv
module serin_width_ctl
  import serin_pkg::*;
#(
  parameter int BUF_W = 32,
  parameter int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_fire,
  input  op_e              op,
  input  logic [CNT_W-1:0] arg,
  output logic [CNT_W-1:0] tw,
  output logic [CNT_W-1:0] psc,
  output logic             armed,
  output logic             bad,
  output logic [CNT_W-1:0] read_w
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_W);

  always_comb begin
    bad    = 1'b0;
    read_w = tw;
    unique case (op)
      OP_SETW:  bad = !width_ok(32'(arg), BUF_W);
      OP_ARM:   bad = (arg == '0) || (arg >= tw);
      OP_READ:  read_w = armed ? psc : tw;
      OP_READW: begin
        bad    = !readw_ok(32'(arg), BUF_W);
        read_w = arg;
      end
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tw    <= FULL;
      psc   <= '0;
      armed <= 1'b0;
    end else if (cmd_fire && !bad) begin
      unique case (op)
        OP_SETW: begin
          tw    <= arg;
          armed <= 1'b0;
        end
        OP_ARM: begin
          psc   <= arg;
          armed <= 1'b1;
        end
        default: armed <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/serin_shift_buf.sv
module serin_shift_buf #(
  parameter int BUF_W = 32,
  parameter int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             bit_in,
  input  logic             take,
  input  logic [CNT_W-1:0] take_w,
  output logic [CNT_W-1:0] cnt,
  output logic [BUF_W-1:0] word,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BUF_W);

  logic [BUF_W-1:0] sr;
  logic [BUF_W-1:0] oldest_low;
  logic             accept_bit;

  // A strobe is kept unless the buffer is full and nothing leaves this cycle
  assign accept_bit = bit_stb && ((cnt != FULL) || take);

  // Oldest bit moved to position 0, then the requested run left-aligned
  always_comb begin
    oldest_low = sr >> (FULL - cnt);
    word       = oldest_low << (FULL - take_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      if (accept_bit) sr <= {bit_in, sr[BUF_W-1:1]};
      cnt <= cnt - (take ? take_w : '0) + (accept_bit ? CNT_W'(1) : '0);
      if (bit_stb && !accept_bit) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/serin_port.sv
module serin_port
  import serin_pkg::*;
#(
  parameter int BUF_W = 32,
  parameter int CNT_W = $clog2(BUF_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_stb,
  input  logic             bit_in,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_arg,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [BUF_W-1:0] rsp_data,
  output logic             overrun
);
  logic             pending;
  logic [CNT_W-1:0] pw;
  logic [CNT_W-1:0] tw, psc, read_w, cnt;
  logic             armed, bad, fire, complete;
  logic [BUF_W-1:0] word;
  op_e              op;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = !pending;
  assign fire      = cmd_valid && cmd_ready;
  assign complete  = pending && (cnt >= pw);

  serin_width_ctl #(.BUF_W(BUF_W), .CNT_W(CNT_W)) u_wctl (
    .clk(clk), .rst(rst), .cmd_fire(fire), .op(op), .arg(cmd_arg),
    .tw(tw), .psc(psc), .armed(armed), .bad(bad), .read_w(read_w)
  );

  serin_shift_buf #(.BUF_W(BUF_W), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .bit_in(bit_in),
    .take(complete), .take_w(pw), .cnt(cnt), .word(word), .overrun(overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= 1'b0;
      pw        <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (complete) begin
        pending   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b0;
        rsp_data  <= word;
      end
      if (fire) begin
        if (bad) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_data  <= '0;
        end else if (op == OP_READ || op == OP_READW) begin
          pending <= 1'b1;
          pw      <= read_w;
        end else begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_data  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/serin_port_chk.sv
module serin_port_chk #(
  parameter int BUF_W = 32,
  parameter int CNT_W = $clog2(BUF_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tw,
  input logic [CNT_W-1:0] psc,
  input logic             armed,
  input logic             pending,
  input logic [CNT_W-1:0] pw,
  input logic             rsp_valid,
  input logic             overrun
);
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) <= BUF_W);

  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r3_width_legal: assert property (@(posedge clk) disable iff (rst)
    (32'(tw) == 1) || (32'(tw) == 4) || (32'(tw) == 8) || (32'(tw) == BUF_W));

  a_r6_arm_below_width: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((psc != '0) && (psc < tw)));

  a_r8_no_early_rsp: assert property (@(posedge clk) disable iff (rst)
    (pending && (cnt < pw)) |=> !rsp_valid);
endmodule

bind serin_port serin_port_chk #(.BUF_W(BUF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .tw(tw), .psc(psc), .armed(armed),
  .pending(pending), .pw(pw), .rsp_valid(rsp_valid), .overrun(overrun)
);

// File: tb/serin_port_tb.sv
module serin_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_W = 32;
  localparam int CNT_W = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic bit_stb = 1'b0, bit_in = 1'b0, cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [CNT_W-1:0] cmd_arg = '0;
  logic cmd_ready, rsp_valid, rsp_err, overrun;
  logic [BUF_W-1:0] rsp_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serin_port u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lalign(logic [31:0] pat, int n);
    return pat << (32 - n);
  endfunction

  task automatic push_bits(logic [31:0] pat, int n);
    for (int i = 0; i < n; i++) begin
      bit_stb = 1'b1; bit_in = pat[i];
      @(negedge clk);
    end
    bit_stb = 1'b0;
  endtask

  task automatic issue(logic [1:0] op, int arg);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = CNT_W'(arg);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    for (int i = 0; i < 200; i++) begin
      if (rsp_valid) return;
      @(negedge clk);
    end
  endtask

  task automatic cfg(string req, logic [1:0] op, int arg, logic exp_err);
    issue(op, arg);
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " rsp_err"}, 32'(rsp_err), 32'(exp_err));
  endtask

  task automatic rd(string req, logic [1:0] op, int arg, logic [31:0] exp);
    issue(op, arg);
    wait_rsp();
    chk({req, " read valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " read err"}, 32'(rsp_err), 32'd0);
    chk({req, " read data"}, rsp_data, exp);
  endtask

  task automatic t_reset();
    chk("R1 cmd_ready", 32'(cmd_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 overrun", 32'(overrun), 32'd0);
  endtask

  task automatic t_full_word();
    push_bits(32'hA5C3_1E69, 32);
    rd("R1 R2 default 32-bit LSB first", 2'd2, 0, 32'hA5C3_1E69);
  endtask

  task automatic t_set_width();
    cfg("R3 reject width 5", 2'd0, 5, 1'b1);
    push_bits(32'h1357_9BDF, 32);
    rd("R3 width unchanged after reject", 2'd2, 0, 32'h1357_9BDF);
    cfg("R3 accept width 8", 2'd0, 8, 1'b0);
    push_bits(32'h0000_00B4, 8);
    rd("R4 8-bit word left-aligned", 2'd2, 0, lalign(32'hB4, 8));
  endtask

  task automatic t_one_shot();
    cfg("R5 arm 3", 2'd1, 3, 1'b0);
    push_bits(32'h5, 3);
    rd("R5 one-shot 3 bits", 2'd2, 0, lalign(32'h5, 3));
    push_bits(32'h6C, 8);
    rd("R5 reverts to width 8", 2'd2, 0, lalign(32'h6C, 8));
    cfg("R6 arm equal to width rejected", 2'd1, 8, 1'b1);
    cfg("R6 arm zero rejected", 2'd1, 0, 1'b1);
    push_bits(32'h93, 8);
    rd("R6 nothing armed after reject", 2'd2, 0, lalign(32'h93, 8));
  endtask

  task automatic t_setw_cancels();
    cfg("R11 arm 2", 2'd1, 2, 1'b0);
    cfg("R11 set width 4", 2'd0, 4, 1'b0);
    push_bits(32'hD, 4);
    rd("R11 one-shot dropped by width change", 2'd2, 0, lalign(32'hD, 4));
  endtask

  task automatic t_sized_read();
    push_bits(32'h0000_C3A5, 16);
    cfg("R7 sized read 9 rejected", 2'd3, 9, 1'b1);
    rd("R7 sized read 16 no bits lost", 2'd3, 16, lalign(32'hC3A5, 16));
    push_bits(32'h00F0_0F5A, 24);
    rd("R7 sized read 24", 2'd3, 24, lalign(32'h00F0_0F5A, 24));
    cfg("R7 arm 3 before sized read", 2'd1, 3, 1'b0);
    push_bits(32'h6, 5);
    rd("R7 sized read 5", 2'd3, 5, lalign(32'h6, 5));
    push_bits(32'h9, 4);
    rd("R7 one-shot cancelled by sized read", 2'd2, 0, lalign(32'h9, 4));
  endtask

  task automatic t_carry();
    push_bits(32'h35, 6);
    rd("R10 first of carried bits", 2'd2, 0, lalign(32'h5, 4));
    push_bits(32'h2, 2);
    rd("R10 carried bits lead next word", 2'd2, 0, lalign(32'hB, 4));
  endtask

  task automatic t_stall();
    issue(2'd2, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R8 ready low while waiting", 32'(cmd_ready), 32'd0);
      chk("R8 no response while waiting", 32'(rsp_valid), 32'd0);
      @(negedge clk);
    end
    push_bits(32'h7, 3);
    chk("R8 no response after 3 of 4 bits", 32'(rsp_valid), 32'd0);
    push_bits(32'h1, 1);
    chk("R8 response not on recording edge", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R8 response one edge later", 32'(rsp_valid), 32'd1);
    chk("R8 stalled read data", rsp_data, lalign(32'hF, 4));
  endtask

  task automatic t_overrun();
    cfg("R9 set width 32", 2'd0, 32, 1'b0);
    push_bits(32'h8E1D_4C27, 32);
    chk("R9 no overrun at exactly full", 32'(overrun), 32'd0);
    push_bits(32'h1, 1);
    chk("R9 overrun set by extra bit", 32'(overrun), 32'd1);
    rd("R9 kept bits intact", 2'd2, 0, 32'h8E1D_4C27);
    chk("R9 overrun sticky", 32'(overrun), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_set_width();
    t_one_shot();
    t_setw_cancels();
    t_sized_read();
    t_carry();
    t_stall();
    t_overrun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule